// File: doc/BRIEF.md
# Flash Row Write-Latch Controller

This block stands between a processor-style register interface and a flash array that is organised in words. Software gives it an address, a 14-bit data word and a few control bits. Each protected operation then has to be opened with a short unlock handshake. Data collects in a row of sixteen write latches. A commit sends the whole row to the flash array as a single row-program command. A separate command erases one whole row.

The low address bits pick a latch and the upper bits name the flash row, so no operation can reach into a neighbouring row. The load-only control bit decides what a completed unlock does. With the bit set, it only fills one latch. With the bit clear, it fills the latch and then programs the row. Programming never erases first. After every program or erase, all latches return to the blank word 0x3FFF, so latches that were never loaded program as blank. The flash array is an abstract request/acknowledge port.

Top module: `flash_row_latch`

## Requirements
- R1: After reset every latch holds 0x3FFF, busy is low and the write-enable bit is clear, so an unlock and go that come before any control write start nothing.
- R2: Address bits [3:0] select the latch. Bits [8:4] are presented as the row on `fl_row` for the whole of a flash operation.
- R3: With load-only = 1, a completed unlock writes the data register into the addressed latch. The latch shows on `fl_data[i*14 +: 14]` in the cycle after go, and no flash request is raised.
- R4: With load-only = 0 and erase = 0, a completed unlock writes the addressed latch and raises `fl_req`/`busy` in the cycle after go, with `fl_erase` = 0 and all sixteen latches on `fl_data`.
- R5: In the cycle after the acknowledge of any program or erase, every latch reads 0x3FFF.
- R6: With the erase bit set, a completed unlock raises a row-erase request (`fl_erase` = 1) for the addressed row and loads no latch.
- R7: The unlock is key 0x55, then key 0xAA on the next cycle, then go on the cycle after that. A gap, a wrong key or any register write in between cancels it, and a cancelled sequence has no effect.
- R8: Busy stays high until `fl_ack` is sampled, and it is low in the following cycle.
- R9: While busy, key writes, go and register writes are ignored, and the latches, row and command stay stable.
- R10: A completed unlock does nothing unless write-enable is 1 and config-select is 0.
- R11: The address register never advances by itself. A second load without an address write overwrites the same latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Write strobe for the address register |
| addr_in | input | 9 | New address |
| data_we | input | 1 | Write strobe for the data register |
| data_in | input | 14 | New data word |
| ctrl_we | input | 1 | Write strobe for the control bits |
| ctrl_wren | input | 1 | Write-enable bit |
| ctrl_load_only | input | 1 | 1 = load latch only, 0 = load and program the row |
| ctrl_cfg_sel | input | 1 | Configuration-space select; must be 0 |
| ctrl_erase | input | 1 | Request a row erase instead of a load |
| key_we | input | 1 | Unlock key write strobe |
| key_in | input | 8 | Unlock key value |
| go | input | 1 | Go strobe that ends the unlock sequence |
| fl_req | output | 1 | Flash operation request, held until acknowledged |
| fl_erase | output | 1 | 1 = row erase, 0 = row program |
| fl_row | output | 5 | Target flash row |
| fl_data | output | 224 | Sixteen 14-bit latches, latch i at bits [i*14 +: 14] |
| fl_ack | input | 1 | Flash completion acknowledge |
| busy | output | 1 | Flash operation in progress |

## Verification
Register writes and keys take effect at the edge that samples them. A latch load, a raised request and a new row value are therefore visible one cycle after go, and busy and blank latches are visible one cycle after the acknowledge. The bench keeps a behavioural model that takes the same inputs at each rising edge. It compares busy, request, erase flag, row and the full latch image on every falling edge, so each result is checked in the exact cycle it becomes due and in no other. Directed checks after each scenario sample at the same falling edges, and the flash acknowledge is driven a few cycles into each operation so the held state is observed.

// File: rtl/flash_row_latch.sv
module flash_row_latch #(
  parameter int LATCHES = 16,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 14,
  parameter int KEY_W   = 8,
  parameter logic [KEY_W-1:0]  KEY_A = 8'h55,
  parameter logic [KEY_W-1:0]  KEY_B = 8'hAA,
  parameter logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        addr_we,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic                        data_we,
  input  logic [DATA_W-1:0]           data_in,
  input  logic                        ctrl_we,
  input  logic                        ctrl_wren,
  input  logic                        ctrl_load_only,
  input  logic                        ctrl_cfg_sel,
  input  logic                        ctrl_erase,
  input  logic                        key_we,
  input  logic [KEY_W-1:0]            key_in,
  input  logic                        go,
  output logic                        fl_req,
  output logic                        fl_erase,
  output logic [ADDR_W-$clog2(LATCHES)-1:0] fl_row,
  output logic [LATCHES*DATA_W-1:0]   fl_data,
  input  logic                        fl_ack,
  output logic                        busy
);
  localparam int IDX_W = $clog2(LATCHES);
  localparam int ROW_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {SQ_IDLE, SQ_KEYA, SQ_KEYB} seq_t;

  logic [ADDR_W-1:0]               addr_q;
  logic [DATA_W-1:0]               data_q;
  logic                            wren_q, lo_q, cfg_q, er_q;
  seq_t                            seq_q, seq_d;
  logic [LATCHES-1:0][DATA_W-1:0]  lat_q;
  logic                            busy_q, erase_q;
  logic [ROW_W-1:0]                row_q;

  logic reg_wr, fire, allowed, start, done, clean_key;

  assign reg_wr    = addr_we | data_we | ctrl_we;
  assign clean_key = key_we & ~reg_wr & ~go;
  assign fire      = ~busy_q & (seq_q == SQ_KEYB) & go & ~key_we & ~reg_wr;
  assign allowed   = fire & wren_q & ~cfg_q;
  assign start     = allowed & (er_q | ~lo_q);
  assign done      = busy_q & fl_ack;

  always_comb begin
    seq_d = SQ_IDLE;
    if (!busy_q && clean_key) begin
      if (key_in == KEY_A)                               seq_d = SQ_KEYA;
      else if (key_in == KEY_B && seq_q == SQ_KEYA)      seq_d = SQ_KEYB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= SQ_IDLE;
    else        seq_q <= seq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wren_q <= 1'b0;
      lo_q   <= 1'b0;
      cfg_q  <= 1'b0;
      er_q   <= 1'b0;
    end else if (!busy_q) begin
      if (addr_we) addr_q <= addr_in;
      if (data_we) data_q <= data_in;
      if (ctrl_we) begin
        wren_q <= ctrl_wren;
        lo_q   <= ctrl_load_only;
        cfg_q  <= ctrl_cfg_sel;
        er_q   <= ctrl_erase;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LATCHES; i++) lat_q[i] <= BLANK;
    end else if (done) begin
      for (int i = 0; i < LATCHES; i++) lat_q[i] <= BLANK;
    end else if (allowed && !er_q) begin
      lat_q[addr_q[IDX_W-1:0]] <= data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      row_q   <= '0;
    end else if (done) begin
      busy_q  <= 1'b0;
    end else if (start) begin
      busy_q  <= 1'b1;
      erase_q <= er_q;
      row_q   <= addr_q[ADDR_W-1:IDX_W];
    end
  end

  assign busy     = busy_q;
  assign fl_req   = busy_q;
  assign fl_erase = erase_q;
  assign fl_row   = row_q;

  for (genvar g = 0; g < LATCHES; g++) begin : g_pack
    assign fl_data[g*DATA_W +: DATA_W] = lat_q[g];
  end
endmodule

module flash_row_latch_chk #(
  parameter int LATCHES = 16,
  parameter int ROW_W   = 5,
  parameter int DATA_W  = 14,
  parameter logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}}
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      go,
  input logic                      busy,
  input logic                      fl_ack,
  input logic                      fl_erase,
  input logic [ROW_W-1:0]          fl_row,
  input logic [LATCHES*DATA_W-1:0] fl_data
);
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy && !fl_ack |=> busy); // R8
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n) busy && fl_ack |=> !busy); // R8
  AST_BLANK_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n) busy && fl_ack |=> fl_data == {LATCHES{BLANK}}); // R5
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) busy && !fl_ack |=> $stable(fl_row) && $stable(fl_erase) && $stable(fl_data)); // R9
  AST_GO_NEEDED: assert property (@(posedge clk) disable iff (!rst_n) !busy && !go |=> !busy); // R7
endmodule

bind flash_row_latch flash_row_latch_chk #(
  .LATCHES(LATCHES), .ROW_W(ROW_W), .DATA_W(DATA_W), .BLANK(BLANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .fl_ack(fl_ack),
  .fl_erase(fl_erase), .fl_row(fl_row), .fl_data(fl_data)
);

// File: tb/flash_row_latch_tb.sv
module flash_row_latch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_we = 0, data_we = 0, ctrl_we = 0, key_we = 0, go = 0, fl_ack = 0;
  logic [8:0]  addr_in = '0;
  logic [13:0] data_in = '0;
  logic ctrl_wren = 0, ctrl_load_only = 0, ctrl_cfg_sel = 0, ctrl_erase = 0;
  logic [7:0]  key_in = '0;
  logic fl_req, fl_erase, busy;
  logic [4:0]   fl_row;
  logic [223:0] fl_data;

  int checks = 0, fails = 0, cyc = 0;

  // Behavioural reference state
  logic [13:0] m_lat [16];
  int   m_seq = 0;
  bit   m_busy = 0, m_erase = 0, m_wren = 0, m_lo = 0, m_cfg = 0, m_er = 0;
  int   m_row = 0, m_addr = 0, m_data = 0;

  always #2 clk = ~clk;

  flash_row_latch u_dut (
    .clk(clk), .rst_n(rst_n),
    .addr_we(addr_we), .addr_in(addr_in), .data_we(data_we), .data_in(data_in),
    .ctrl_we(ctrl_we), .ctrl_wren(ctrl_wren), .ctrl_load_only(ctrl_load_only),
    .ctrl_cfg_sel(ctrl_cfg_sel), .ctrl_erase(ctrl_erase),
    .key_we(key_we), .key_in(key_in), .go(go),
    .fl_req(fl_req), .fl_erase(fl_erase), .fl_row(fl_row), .fl_data(fl_data),
    .fl_ack(fl_ack), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  // Reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lat[i]) m_lat[i] = 14'h3FFF;
      m_seq = 0; m_busy = 0; m_erase = 0; m_row = 0;
      m_wren = 0; m_lo = 0; m_cfg = 0; m_er = 0; m_addr = 0; m_data = 0;
    end else if (m_busy) begin
      m_seq = 0;
      if (fl_ack) begin
        m_busy = 0;
        foreach (m_lat[i]) m_lat[i] = 14'h3FFF;
      end
    end else begin
      bit wr, fire;
      wr = addr_we || data_we || ctrl_we;
      fire = (m_seq == 2) && go && !key_we && !wr;
      if (fire && m_wren && !m_cfg) begin
        if (m_er) begin
          m_busy = 1; m_erase = 1; m_row = m_addr / 16;
        end else begin
          m_lat[m_addr % 16] = m_data[13:0];
          if (!m_lo) begin m_busy = 1; m_erase = 0; m_row = m_addr / 16; end
        end
      end
      if (key_we && !wr && !go && key_in == 8'h55) m_seq = 1;
      else if (key_we && !wr && !go && key_in == 8'hAA && m_seq == 1) m_seq = 2;
      else m_seq = 0;
      if (addr_we) m_addr = addr_in;
      if (data_we) m_data = data_in;
      if (ctrl_we) begin
        m_wren = ctrl_wren; m_lo = ctrl_load_only; m_cfg = ctrl_cfg_sel; m_er = ctrl_erase;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [223:0] exp;
      foreach (m_lat[i]) exp[i*14 +: 14] = m_lat[i];
      chk(busy == m_busy, "R8 busy", busy, m_busy);
      chk(fl_req == m_busy, "R4 fl_req", fl_req, m_busy);
      chk(fl_data == exp, "R5 latches", fl_data, exp);
      if (m_busy) begin
        chk(fl_row == m_row[4:0], "R2 row", fl_row, m_row);
        chk(fl_erase == m_erase, "R6 erase flag", fl_erase, m_erase);
      end
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic w_addr(input logic [8:0] a);
    addr_we = 1; addr_in = a; step(); addr_we = 0;
  endtask
  task automatic w_data(input logic [13:0] d);
    data_we = 1; data_in = d; step(); data_we = 0;
  endtask
  task automatic w_ctrl(input bit we, input bit lo, input bit cs, input bit er);
    ctrl_we = 1; ctrl_wren = we; ctrl_load_only = lo; ctrl_cfg_sel = cs; ctrl_erase = er;
    step(); ctrl_we = 0;
  endtask
  task automatic w_key(input logic [7:0] k);
    key_we = 1; key_in = k; step(); key_we = 0;
  endtask
  task automatic pulse_go(); go = 1; step(); go = 0; endtask
  task automatic unlock(); w_key(8'h55); w_key(8'hAA); pulse_go(); endtask
  task automatic ack_after(input int n);
    repeat (n) step();
    fl_ack = 1; step(); fl_ack = 0;
  endtask

  function automatic logic [13:0] lat(input int i);
    return fl_data[i*14 +: 14];
  endfunction

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    chk(busy == 0 && fl_data == {16{14'h3FFF}}, "R1 reset state", {busy, fl_data}, {1'b0, {16{14'h3FFF}}});

    unlock();
    chk(busy == 0, "R1 write-enable clear after reset", busy, 0);

    w_ctrl(1, 1, 0, 0); w_addr(9'h023); w_data(14'h0ABC);
    unlock();
    chk(lat(3) == 14'h0ABC && busy == 0, "R3 load-only latch 3", {busy, lat(3)}, {1'b0, 14'h0ABC});

    w_addr(9'h025); w_data(14'h1111);
    w_key(8'h55); step(); w_key(8'hAA); pulse_go();
    chk(lat(5) == 14'h3FFF, "R7 gap cancels", lat(5), 14'h3FFF);
    w_key(8'h55); w_key(8'hAA); w_data(14'h1111); pulse_go();
    chk(lat(5) == 14'h3FFF, "R7 register write cancels", lat(5), 14'h3FFF);
    w_key(8'hAA); w_key(8'h55); pulse_go();
    chk(lat(5) == 14'h3FFF, "R7 wrong order cancels", lat(5), 14'h3FFF);

    unlock();
    chk(lat(5) == 14'h1111, "R3 load-only latch 5", lat(5), 14'h1111);
    w_data(14'h1234);
    unlock();
    chk(lat(5) == 14'h1234 && lat(6) == 14'h3FFF, "R11 no address advance", {lat(6), lat(5)}, {14'h3FFF, 14'h1234});

    w_ctrl(1, 1, 1, 0); w_data(14'h0777);
    unlock();
    chk(lat(5) == 14'h1234, "R10 config select blocks", lat(5), 14'h1234);
    w_ctrl(0, 1, 0, 0);
    unlock();
    chk(lat(5) == 14'h1234, "R10 write-enable clear blocks", lat(5), 14'h1234);

    w_ctrl(1, 0, 0, 0); w_addr(9'h02F); w_data(14'h2222);
    unlock();
    chk(busy && fl_req && !fl_erase && fl_row == 5'd2, "R4 commit request", {busy, fl_erase, fl_row}, {1'b1, 1'b0, 5'd2});
    chk(lat(15) == 14'h2222 && lat(3) == 14'h0ABC && lat(5) == 14'h1234, "R4 row image", {lat(15), lat(5), lat(3)}, {14'h2222, 14'h1234, 14'h0ABC});
    w_addr(9'h000); w_data(14'h3333); w_ctrl(1, 1, 0, 0);
    unlock();
    chk(busy == 1 && lat(0) == 14'h3FFF, "R9 ignored while busy", {busy, lat(0)}, {1'b1, 14'h3FFF});
    ack_after(2);
    chk(busy == 0 && fl_data == {16{14'h3FFF}}, "R5 blank after program", {busy, fl_data}, {1'b0, {16{14'h3FFF}}});
    chk(busy == 0, "R8 busy drops after ack", busy, 0);

    w_ctrl(1, 1, 0, 0);
    unlock();
    chk(lat(15) == 14'h2222, "R9 address and data kept", lat(15), 14'h2222);

    w_ctrl(1, 1, 0, 1); w_addr(9'h040);
    unlock();
    chk(busy && fl_erase && fl_row == 5'd4 && lat(0) == 14'h3FFF && lat(15) == 14'h2222,
        "R6 row erase", {fl_erase, fl_row, lat(15)}, {1'b1, 5'd4, 14'h2222});
    ack_after(4);
    chk(fl_data == {16{14'h3FFF}}, "R5 blank after erase", fl_data, {16{14'h3FFF}});

    w_ctrl(1, 0, 0, 0); w_addr(9'h1FF); w_data(14'h0155);
    unlock();
    chk(fl_row == 5'd31 && lat(15) == 14'h0155 && lat(0) == 14'h3FFF, "R2 top row boundary",
        {fl_row, lat(15)}, {5'd31, 14'h0155});
    ack_after(1);
    step();
    finish_run();
  end
endmodule